// File: doc/BRIEF.md
# Software-Directed Fault Recovery Controller

This block sits beside the pipeline of a simple in-order core and lets software recover from hardware faults without any hardware checkpointing. Software opens a relaxed region with a region-entry instruction that carries the address of a recovery handler. While the region is open, instructions keep retiring and may commit corrupted results. When a separate fault detector reports a problem, the controller forces the next fetch to the stored handler. Software then decides whether to retry or discard the work.

The detector reports a fault a fixed number of cycles after the faulty instruction executes (parameter `DET_LAT`). For that reason the region stays sensitive to faults for `DET_LAT` cycles after the region-exit instruction. For the same reason, a hardware exception raised inside a region is held until detection for older instructions has settled. If a fault is confirmed while the exception is held, the redirect takes precedence and the exception is dropped. Atomic read-modify-write operations issued inside an open region are flagged as illegal. A per-core enable turns relaxed behaviour off at run time. While it is off, faults are reported as machine errors. Outputs are registered: each one reflects the inputs of the previous clock cycle.

Top module: `relax_recovery_ctrl`

## Requirements
- R1: An entry (`entry_valid`=1) with no redirect in the same cycle stores `entry_addr`, with its low `ALIGN_LSB` bits forced to zero, as the recovery address and opens the region. A later redirect presents exactly that address on `redirect_pc`.
- R2: A fault (`fault_pulse`=1) while the region is active and `relax_enable`=1 produces a one-cycle `redirect_valid` in the next cycle and closes the region. A further fault then counts as outside.
- R3: An exit (`exit_valid`=1) in an open region keeps the region active for the next `DET_LAT` cycles. A fault in any of those cycles redirects. A fault in the cycle after them raises `machine_err`.
- R4: A fault while no region is active, or while `relax_enable`=0, pulses `machine_err` for one cycle in the next cycle and never asserts `redirect_valid`.
- R5: An exception request first seen at clock edge t while the region is active and `relax_enable`=1 is granted with a one-cycle `exc_grant` at edge t+`DET_LAT`, if `exc_req` stays high and no redirect occurs. Otherwise a request is granted at the next edge. Each request gets at most one grant until `exc_req` falls. A request withdrawn during the wait is never granted.
- R6: A redirect at any edge from the first sighting of a held exception up to its grant edge drops the exception. No grant follows until `exc_req` has fallen and risen again.
- R7: `atomic_issue` while the region is open (not in its exit tail) and `relax_enable`=1 pulses `atomic_err` in the next cycle. At any other time it has no effect.
- R8: An entry while the region is already open replaces the recovery address and sets `nest_err`, which stays high until reset. An entry during the exit tail does not set it.
- R9: With `relax_enable`=0 the region state and recovery address are kept. Exceptions are granted at the next edge. A fault after re-enabling still redirects to the stored address.
- R10: When entry and exit arrive in the same cycle, the entry wins and the exit is ignored. The region stays open with no tail countdown.
- R11: Asynchronous active-low reset clears every output and the region state, so a fault right after reset gives `machine_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| relax_enable | input | 1 | Per-core relaxed-mode enable |
| entry_valid | input | 1 | Region-entry instruction executes |
| entry_addr | input | PC_W | Handler address operand of the entry instruction |
| exit_valid | input | 1 | Region-exit instruction executes |
| fault_pulse | input | 1 | Fault report from the detector |
| exc_req | input | 1 | Hardware exception request, held until granted or dropped |
| atomic_issue | input | 1 | Atomic read-modify-write issued |
| redirect_valid | output | 1 | Force the next fetch to `redirect_pc` |
| redirect_pc | output | PC_W | Recovery handler address |
| exc_grant | output | 1 | Exception may be taken |
| atomic_err | output | 1 | Atomic operation illegal in region |
| machine_err | output | 1 | Fault reported as unrecoverable machine error |
| nest_err | output | 1 | Sticky nested-entry flag |

## Verification
The hardest situation to reach is a held exception being overtaken by a fault. The request has to be raised inside an open region and kept high for fewer than `DET_LAT` edges, and the fault must land inside that window. The vector table lines these up cycle by cycle: it opens a region, holds `exc_req` for two cycles, fires the fault in the third, then keeps the request high to show no late grant. The tail boundary gets the same treatment. One fault is placed on the last tail cycle and another on the first cycle after the tail.

// File: rtl/rrc_pkg.sv
package rrc_pkg;

   typedef enum logic [1:0] {
      RG_IDLE = 2'd0,
      RG_OPEN = 2'd1,
      RG_TAIL = 2'd2
   } region_e;

   typedef enum logic [1:0] {
      TG_IDLE = 2'd0,
      TG_WAIT = 2'd1,
      TG_DONE = 2'd2
   } trap_e;

   function automatic int unsigned cnt_width(int unsigned lat);
      return (lat < 2) ? 1 : $clog2(lat + 1);
   endfunction

endpackage

// File: rtl/rrc_region_ctrl.sv
module rrc_region_ctrl
   import rrc_pkg::*;
#(
   parameter int unsigned PC_W      = 32,
   parameter int unsigned ALIGN_LSB = 2,
   parameter int unsigned DET_LAT   = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            entry_valid,
   input  logic [PC_W-1:0] entry_addr,
   input  logic            exit_valid,
   input  logic            take_redirect,
   output logic            region_open,
   output logic            region_active,
   output logic [PC_W-1:0] rpc,
   output logic            nest_err
);
   localparam int unsigned      CNT_W     = cnt_width(DET_LAT);
   localparam logic [CNT_W-1:0] TAIL_LOAD = CNT_W'(DET_LAT);
   localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

   region_e          state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic [PC_W-1:0]  addr_aligned;
   logic             accept_entry;

   generate
      if (ALIGN_LSB > 0) begin : g_align
         assign addr_aligned = {entry_addr[PC_W-1:ALIGN_LSB], {ALIGN_LSB{1'b0}}};
      end else begin : g_noalign
         assign addr_aligned = entry_addr;
      end
   endgenerate

   assign accept_entry = entry_valid && !take_redirect;

   generate
      if (DET_LAT > 0) begin : g_tail
         always_comb begin
            state_d = state_q;
            cnt_d   = cnt_q;
            if (take_redirect) begin
               state_d = RG_IDLE;
               cnt_d   = '0;
            end else if (entry_valid) begin
               state_d = RG_OPEN;
               cnt_d   = '0;
            end else if (exit_valid && state_q == RG_OPEN) begin
               state_d = RG_TAIL;
               cnt_d   = TAIL_LOAD;
            end else if (state_q == RG_TAIL) begin
               cnt_d = cnt_q - CNT_ONE;
               if (cnt_q <= CNT_ONE) begin
                  state_d = RG_IDLE;
               end
            end
         end
      end else begin : g_notail
         always_comb begin
            state_d = state_q;
            cnt_d   = '0;
            if (take_redirect) begin
               state_d = RG_IDLE;
            end else if (entry_valid) begin
               state_d = RG_OPEN;
            end else if (exit_valid && state_q == RG_OPEN) begin
               state_d = RG_IDLE;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= RG_IDLE;
         cnt_q    <= '0;
         rpc      <= '0;
         nest_err <= 1'b0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         if (accept_entry) begin
            rpc <= addr_aligned;
            if (state_q == RG_OPEN) begin
               nest_err <= 1'b1;
            end
         end
      end
   end

   assign region_open   = (state_q == RG_OPEN);
   assign region_active = (state_q != RG_IDLE);

endmodule

// File: rtl/rrc_trap_gate.sv
module rrc_trap_gate
   import rrc_pkg::*;
#(
   parameter int unsigned DET_LAT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic exc_req,
   input  logic region_active,
   input  logic relax_enable,
   input  logic take_redirect,
   output logic exc_grant
);
   localparam int unsigned      CNT_W     = cnt_width(DET_LAT);
   localparam logic [CNT_W-1:0] WAIT_LOAD = CNT_W'(DET_LAT);
   localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);
   localparam bit               HAS_WAIT  = (DET_LAT > 0);

   trap_e            trap_q, trap_d;
   logic [CNT_W-1:0] tcnt_q, tcnt_d;
   logic             grant_d;
   logic             must_hold;

   assign must_hold = region_active && relax_enable;

   always_comb begin
      trap_d  = trap_q;
      tcnt_d  = tcnt_q;
      grant_d = 1'b0;
      unique case (trap_q)
         TG_IDLE: begin
            if (exc_req) begin
               if (must_hold && take_redirect) begin
                  trap_d = TG_DONE;
               end else if (must_hold && HAS_WAIT) begin
                  trap_d = TG_WAIT;
                  tcnt_d = WAIT_LOAD;
               end else begin
                  grant_d = 1'b1;
                  trap_d  = TG_DONE;
               end
            end
         end
         TG_WAIT: begin
            if (!exc_req) begin
               trap_d = TG_IDLE;
               tcnt_d = '0;
            end else if (take_redirect) begin
               trap_d = TG_DONE;
               tcnt_d = '0;
            end else if (tcnt_q <= CNT_ONE) begin
               grant_d = 1'b1;
               trap_d  = TG_DONE;
               tcnt_d  = '0;
            end else begin
               tcnt_d = tcnt_q - CNT_ONE;
            end
         end
         TG_DONE: begin
            if (!exc_req) begin
               trap_d = TG_IDLE;
            end
         end
         default: begin
            trap_d = TG_IDLE;
            tcnt_d = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trap_q    <= TG_IDLE;
         tcnt_q    <= '0;
         exc_grant <= 1'b0;
      end else begin
         trap_q    <= trap_d;
         tcnt_q    <= tcnt_d;
         exc_grant <= grant_d;
      end
   end

endmodule

// File: rtl/rrc_fault_router.sv
module rrc_fault_router #(
   parameter int unsigned PC_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            fault_pulse,
   input  logic            relax_enable,
   input  logic            region_active,
   input  logic            region_open,
   input  logic            atomic_issue,
   input  logic [PC_W-1:0] rpc,
   output logic            take_redirect,
   output logic            redirect_valid,
   output logic [PC_W-1:0] redirect_pc,
   output logic            machine_err,
   output logic            atomic_err
);
   logic relaxed_now;

   assign relaxed_now   = region_active && relax_enable;
   assign take_redirect = fault_pulse && relaxed_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         redirect_valid <= 1'b0;
         redirect_pc    <= '0;
         machine_err    <= 1'b0;
         atomic_err     <= 1'b0;
      end else begin
         redirect_valid <= take_redirect;
         machine_err    <= fault_pulse && !relaxed_now;
         atomic_err     <= atomic_issue && region_open && relax_enable;
         if (take_redirect) begin
            redirect_pc <= rpc;
         end
      end
   end

endmodule

// File: rtl/relax_recovery_ctrl.sv
module relax_recovery_ctrl #(
   parameter int unsigned PC_W      = 32,
   parameter int unsigned ALIGN_LSB = 2,
   parameter int unsigned DET_LAT   = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            relax_enable,
   input  logic            entry_valid,
   input  logic [PC_W-1:0] entry_addr,
   input  logic            exit_valid,
   input  logic            fault_pulse,
   input  logic            exc_req,
   input  logic            atomic_issue,
   output logic            redirect_valid,
   output logic [PC_W-1:0] redirect_pc,
   output logic            exc_grant,
   output logic            atomic_err,
   output logic            machine_err,
   output logic            nest_err
);
   generate
      if (PC_W < 8 || PC_W > 64) begin : g_bad_pc_w
         $error("relax_recovery_ctrl: PC_W must lie in 8..64");
      end
      if (ALIGN_LSB >= PC_W) begin : g_bad_align
         $error("relax_recovery_ctrl: ALIGN_LSB must be below PC_W");
      end
      if (DET_LAT > 255) begin : g_bad_lat
         $error("relax_recovery_ctrl: DET_LAT must not exceed 255");
      end
   endgenerate

   logic            take_redirect;
   logic            region_open;
   logic            region_active;
   logic [PC_W-1:0] rpc;

   rrc_region_ctrl #(
      .PC_W      (PC_W),
      .ALIGN_LSB (ALIGN_LSB),
      .DET_LAT   (DET_LAT)
   ) u_region (
      .clk           (clk),
      .rst_n         (rst_n),
      .entry_valid   (entry_valid),
      .entry_addr    (entry_addr),
      .exit_valid    (exit_valid),
      .take_redirect (take_redirect),
      .region_open   (region_open),
      .region_active (region_active),
      .rpc           (rpc),
      .nest_err      (nest_err)
   );

   rrc_fault_router #(
      .PC_W (PC_W)
   ) u_router (
      .clk            (clk),
      .rst_n          (rst_n),
      .fault_pulse    (fault_pulse),
      .relax_enable   (relax_enable),
      .region_active  (region_active),
      .region_open    (region_open),
      .atomic_issue   (atomic_issue),
      .rpc            (rpc),
      .take_redirect  (take_redirect),
      .redirect_valid (redirect_valid),
      .redirect_pc    (redirect_pc),
      .machine_err    (machine_err),
      .atomic_err     (atomic_err)
   );

   rrc_trap_gate #(
      .DET_LAT (DET_LAT)
   ) u_trap (
      .clk           (clk),
      .rst_n         (rst_n),
      .exc_req       (exc_req),
      .region_active (region_active),
      .relax_enable  (relax_enable),
      .take_redirect (take_redirect),
      .exc_grant     (exc_grant)
   );

endmodule

// File: rtl/rrc_checker.sv
module rrc_checker #(
   parameter int unsigned PC_W      = 32,
   parameter int unsigned ALIGN_LSB = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic            relax_enable,
   input logic            entry_valid,
   input logic [PC_W-1:0] entry_addr,
   input logic            exit_valid,
   input logic            fault_pulse,
   input logic            exc_req,
   input logic            atomic_issue,
   input logic            redirect_valid,
   input logic [PC_W-1:0] redirect_pc,
   input logic            exc_grant,
   input logic            atomic_err,
   input logic            machine_err,
   input logic            nest_err
);
   localparam logic [63:0]     MASK64   = (ALIGN_LSB == 0) ? 64'd0 : ((64'd1 << ALIGN_LSB) - 64'd1);
   localparam logic [PC_W-1:0] LOW_MASK = MASK64[PC_W-1:0];

   p_aligned_pc_r1: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_valid |-> ((redirect_pc & LOW_MASK) == '0));

   p_redirect_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_valid |-> ($past(fault_pulse) && $past(relax_enable)));

   p_redirect_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_valid |=> !redirect_valid);

   p_machine_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      machine_err |-> $past(fault_pulse));

   p_no_dual_report_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(redirect_valid && machine_err));

   p_grant_needs_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
      exc_grant |-> $past(exc_req));

   p_drop_on_redirect_r6: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_valid |-> !exc_grant);

   p_atomic_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      atomic_err |-> ($past(atomic_issue) && $past(relax_enable)));

   p_nest_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      nest_err |=> nest_err);

   p_nest_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nest_err) |-> $past(entry_valid));

endmodule

bind relax_recovery_ctrl rrc_checker #(
   .PC_W      (PC_W),
   .ALIGN_LSB (ALIGN_LSB)
) u_rrc_checker (.*);

// File: tb/test_relax_recovery_ctrl.sv
`timescale 1ns/1ps
module test_relax_recovery_ctrl;
   localparam int unsigned PC_W      = 32;
   localparam int unsigned ALIGN_LSB = 2;
   localparam int unsigned DET_LAT   = 4;

   typedef struct packed {
      logic            en;
      logic            ent;
      logic [PC_W-1:0] addr;
      logic            ext;
      logic            flt;
      logic            exc;
      logic            atm;
      logic            rv;
      logic [PC_W-1:0] pc;
      logic            eg;
      logic            ae;
      logic            me;
      logic            ne;
      logic [7:0]      req;
   } vec_t;

   function automatic vec_t mk(bit en, bit ent, int unsigned addr, bit ext, bit flt, bit exc, bit atm,
                               bit rv, int unsigned pc, bit eg, bit ae, bit me, bit ne, int unsigned req);
      vec_t v;
      v.en = en; v.ent = ent; v.addr = addr; v.ext = ext; v.flt = flt; v.exc = exc; v.atm = atm;
      v.rv = rv; v.pc = pc; v.eg = eg; v.ae = ae; v.me = me; v.ne = ne; v.req = 8'(req);
      return v;
   endfunction

   localparam int NV = 57;
   // fields: en ent addr ext flt exc atm | rv pc eg ae me ne | requirement
   localparam vec_t VT [NV] = '{
      mk(1,0,'h0000,0,0,0,0, 0,'h0000,0,0,0,0, 11), //  0 R11 quiet
      mk(1,0,'h0000,0,1,0,0, 0,'h0000,0,0,1,0,  4), //  1 R4 fault outside
      mk(1,0,'h0000,0,0,1,0, 0,'h0000,1,0,0,0,  5), //  2 R5 immediate grant
      mk(1,0,'h0000,0,0,1,0, 0,'h0000,0,0,0,0,  5), //  3 R5 one grant per request
      mk(1,0,'h0000,0,0,0,0, 0,'h0000,0,0,0,0,  5), //  4
      mk(1,1,'h1003,0,0,0,0, 0,'h0000,0,0,0,0,  1), //  5 R1 entry, low bits dropped
      mk(1,0,'h0000,0,0,0,1, 0,'h0000,0,1,0,0,  7), //  6 R7 atomic in region
      mk(1,0,'h0000,0,1,0,0, 1,'h1000,0,0,0,0,  1), //  7 R1 R2 redirect
      mk(1,0,'h0000,0,1,0,0, 0,'h0000,0,0,1,0,  2), //  8 R2 region closed
      mk(1,1,'h2000,0,0,0,0, 0,'h0000,0,0,0,0,  3), //  9 R3
      mk(1,0,'h0000,1,0,0,0, 0,'h0000,0,0,0,0,  3), // 10 exit
      mk(1,0,'h0000,0,0,0,0, 0,'h0000,0,0,0,0,  3), // 11 tail 1
      mk(1,0,'h0000,0,0,0,0, 0,'h0000,0,0,0,0,  3), // 12 tail 2
      mk(1,0,'h0000,0,0,0,0, 0,'h0000,0,0,0,0,  3), // 13 tail 3
      mk(1,0,'h0000,0,1,0,0, 1,'h2000,0,0,0,0,  3), // 14 R3 fault on last tail cycle
      mk(1,0,'h0000,0,0,0,0, 0,'h0000,0,0,0,0,  3), // 15
      mk(1,1,'h3000,0,0,0,0, 0,'h0000,0,0,0,0,  3), // 16
      mk(1,0,'h0000,1,0,0,0, 0,'h0000,0,0,0,0,  3), // 17 exit
      mk(1,0,'h0000,0,0,0,0, 0,'h0000,0,0,0,0,  3), // 18
      mk(1,0,'h0000,0,0,0,0, 0,'h0000,0,0,0,0,  3), // 19
      mk(1,0,'h0000,0,0,0,0, 0,'h0000,0,0,0,0,  3), // 20
      mk(1,0,'h0000,0,0,0,0, 0,'h0000,0,0,0,0,  3), // 21 last tail cycle
      mk(1,0,'h0000,0,1,0,0, 0,'h0000,0,0,1,0,  3), // 22 R3 fault after tail
      mk(1,1,'h4000,0,0,0,0, 0,'h0000,0,0,0,0,  8), // 23 R8
      mk(1,1,'h5000,0,0,0,0, 0,'h0000,0,0,0,1,  8), // 24 R8 nested entry
      mk(1,0,'h0000,0,1,0,0, 1,'h5000,0,0,0,1,  8), // 25 R8 replaced address
      mk(1,1,'h6000,0,0,0,0, 0,'h0000,0,0,0,1,  5), // 26
      mk(1,0,'h0000,0,0,1,0, 0,'h0000,0,0,0,1,  5), // 27 R5 held exception
      mk(1,0,'h0000,0,0,1,0, 0,'h0000,0,0,0,1,  5), // 28
      mk(1,0,'h0000,0,0,1,0, 0,'h0000,0,0,0,1,  5), // 29
      mk(1,0,'h0000,0,0,1,0, 0,'h0000,0,0,0,1,  5), // 30
      mk(1,0,'h0000,0,0,1,0, 0,'h0000,1,0,0,1,  5), // 31 R5 grant after DET_LAT
      mk(1,0,'h0000,0,0,1,0, 0,'h0000,0,0,0,1,  5), // 32
      mk(1,0,'h0000,0,0,0,0, 0,'h0000,0,0,0,1,  5), // 33
      mk(1,0,'h0000,0,0,1,0, 0,'h0000,0,0,0,1,  6), // 34 R6
      mk(1,0,'h0000,0,0,1,0, 0,'h0000,0,0,0,1,  6), // 35
      mk(1,0,'h0000,0,1,1,0, 1,'h6000,0,0,0,1,  6), // 36 R6 redirect drops exception
      mk(1,0,'h0000,0,0,1,0, 0,'h0000,0,0,0,1,  6), // 37 R6 no late grant
      mk(1,0,'h0000,0,0,0,0, 0,'h0000,0,0,0,1,  6), // 38
      mk(1,0,'h0000,0,0,1,0, 0,'h0000,1,0,0,1,  6), // 39 R6 new request granted
      mk(1,0,'h0000,0,0,0,0, 0,'h0000,0,0,0,1,  6), // 40
      mk(1,1,'h7000,0,0,0,0, 0,'h0000,0,0,0,1,  9), // 41 R9
      mk(0,0,'h0000,0,1,0,0, 0,'h0000,0,0,1,1,  9), // 42 R9 disabled fault
      mk(0,0,'h0000,0,0,0,1, 0,'h0000,0,0,0,1,  9), // 43 R9 atomic ignored
      mk(0,0,'h0000,0,0,1,0, 0,'h0000,1,0,0,1,  9), // 44 R9 immediate grant
      mk(1,0,'h0000,0,1,0,0, 1,'h7000,0,0,0,1,  9), // 45 R9 region kept
      mk(1,1,'h8000,1,0,0,0, 0,'h0000,0,0,0,1, 10), // 46 R10 entry+exit
      mk(1,0,'h0000,0,0,0,0, 0,'h0000,0,0,0,1, 10), // 47
      mk(1,0,'h0000,0,0,0,0, 0,'h0000,0,0,0,1, 10), // 48
      mk(1,0,'h0000,0,0,0,0, 0,'h0000,0,0,0,1, 10), // 49
      mk(1,0,'h0000,0,0,0,0, 0,'h0000,0,0,0,1, 10), // 50
      mk(1,0,'h0000,0,0,0,0, 0,'h0000,0,0,0,1, 10), // 51
      mk(1,0,'h0000,0,1,0,0, 1,'h8000,0,0,0,1, 10), // 52 R10 still open
      mk(1,1,'h9000,0,0,0,0, 0,'h0000,0,0,0,1,  7), // 53 R7
      mk(1,0,'h0000,1,0,0,0, 0,'h0000,0,0,0,1,  7), // 54 exit
      mk(1,0,'h0000,0,0,0,1, 0,'h0000,0,0,0,1,  7), // 55 R7 atomic in tail ignored
      mk(1,0,'h0000,0,1,0,0, 1,'h9000,0,0,0,1,  3)  // 56 R3 tail redirect
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            relax_enable = 1'b0;
   logic            entry_valid = 1'b0;
   logic [PC_W-1:0] entry_addr = '0;
   logic            exit_valid = 1'b0;
   logic            fault_pulse = 1'b0;
   logic            exc_req = 1'b0;
   logic            atomic_issue = 1'b0;
   logic            redirect_valid;
   logic [PC_W-1:0] redirect_pc;
   logic            exc_grant;
   logic            atomic_err;
   logic            machine_err;
   logic            nest_err;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   relax_recovery_ctrl #(
      .PC_W      (PC_W),
      .ALIGN_LSB (ALIGN_LSB),
      .DET_LAT   (DET_LAT)
   ) i_relax_recovery_ctrl (
      .clk            (clk),
      .rst_n          (rst_n),
      .relax_enable   (relax_enable),
      .entry_valid    (entry_valid),
      .entry_addr     (entry_addr),
      .exit_valid     (exit_valid),
      .fault_pulse    (fault_pulse),
      .exc_req        (exc_req),
      .atomic_issue   (atomic_issue),
      .redirect_valid (redirect_valid),
      .redirect_pc    (redirect_pc),
      .exc_grant      (exc_grant),
      .atomic_err     (atomic_err),
      .machine_err    (machine_err),
      .nest_err       (nest_err)
   );

   task automatic drive(vec_t v);
      relax_enable = v.en;
      entry_valid  = v.ent;
      entry_addr   = v.addr;
      exit_valid   = v.ext;
      fault_pulse  = v.flt;
      exc_req      = v.exc;
      atomic_issue = v.atm;
   endtask

   task automatic check(string tag, vec_t v);
      bit bad;
      n_checks++;
      bad = (redirect_valid !== v.rv) || (exc_grant !== v.eg) || (atomic_err !== v.ae) ||
            (machine_err !== v.me) || (nest_err !== v.ne) || (v.rv && (redirect_pc !== v.pc));
      if (bad) begin
         n_fails++;
         $display("FAIL R%0d %s: actual rv=%b pc=%h eg=%b ae=%b me=%b ne=%b expected rv=%b pc=%h eg=%b ae=%b me=%b ne=%b",
                  v.req, tag, redirect_valid, redirect_pc, exc_grant, atomic_err, machine_err, nest_err,
                  v.rv, v.pc, v.eg, v.ae, v.me, v.ne);
      end
   endtask

   task automatic step(string tag, vec_t v);
      drive(v);
      @(negedge clk);
      check(tag, v);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fails++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      // R11: outputs cleared during reset
      repeat (3) @(negedge clk);
      check("reset state", mk(0,0,0,0,0,0,0, 0,0,0,0,0,0, 11));
      rst_n = 1'b1;
      @(negedge clk);

      for (int k = 0; k < NV; k++) begin
         step($sformatf("vector %0d", k), VT[k]);
      end

      // R11: reset in the middle of an open region clears state and sticky flag
      step("r11_open", mk(1,1,'hA000,0,0,0,0, 0,0,0,0,0,1, 11));
      drive(mk(1,0,0,0,0,0,0, 0,0,0,0,0,0, 11));
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("r11_in_reset", mk(1,0,0,0,0,0,0, 0,0,0,0,0,0, 11));
      rst_n = 1'b1;
      @(negedge clk);
      step("r11_fault_after_reset", mk(1,0,0,0,1,0,0, 0,0,0,0,1,0, 11));

      // R5: a request withdrawn during the hold is never granted
      step("r5_open", mk(1,1,'hB000,0,0,0,0, 0,0,0,0,0,0, 5));
      step("r5_req", mk(1,0,0,0,0,1,0, 0,0,0,0,0,0, 5));
      for (int k = 0; k < 6; k++) begin
         step($sformatf("r5_withdrawn %0d", k), mk(1,0,0,0,0,0,0, 0,0,0,0,0,0, 5));
      end
      step("r5_region_kept", mk(1,0,0,0,1,0,0, 1,'hB000,0,0,0,0, 5));

      drive(mk(1,0,0,0,0,0,0, 0,0,0,0,0,0, 11));
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

endmodule